// File: doc/BRIEF.md
# Minimal Five-Operation Load/Store Core

This block is a single-cycle 32-bit processor core for a very small load/store instruction set. Each clock cycle it fetches one instruction through an instruction-memory read port, decodes it, reads up to two registers, computes one sum and one unsigned comparison, and then either writes a register, writes data memory, or changes the program counter. Both memories sit outside the core and answer within the same cycle. The core has no condition flags. The only control transfer is a branch taken when one register is below another in unsigned order. Software detects an unsigned add overflow by comparing the sum against an operand.

The register file has eleven architectural registers: a constant-zero register, a return-address register, a return-value register, a stack pointer and seven temporaries. A 4-bit register field can name sixteen registers. The five indices beyond the implemented set behave like the zero register. The program counter, the branch targets and all data addresses are byte addresses, and the core keeps all of them word aligned.

Top module: `cpu_core`

## Requirements
- R1: Instruction fields are opcode [31:29], rd [28:25], rs1 [24:21], rs2 [20:17] and immediate [15:0]; bit 16 is ignored. Opcodes are 1 add-immediate, 2 add, 3 load-word, 4 store-word, 5 branch-unsigned-less.
- R2: While rst is high at a clock edge, the PC becomes 0 and every register is cleared; the first instruction after reset is fetched from address 0.
- R3: Add-immediate writes rs1 plus the immediate, sign-extended to 32 bits, into rd.
- R4: Add writes rs1 plus rs2 into rd, wrapping modulo 2^32.
- R5: Load-word writes into rd the data word read at address rs1 plus the sign-extended immediate.
- R6: Store-word drives dmem_we for one cycle, with the address rs1 plus the sign-extended immediate and the write data taken from the register named in the rd field; dmem_we is low for every other opcode.
- R7: Branch-unsigned-less compares rs1 and rs2 as unsigned values. When rs1 < rs2, the next PC is PC+4 plus the immediate times 4. Otherwise, including when the two are equal, the next PC is PC+4.
- R8: Register numbering is zero=0, ra=1, a1=2, sp=3, t0..t6=4..10. Register 0 always reads 0, and writes to it are discarded.
- R9: Register indices 11 to 15 read as 0, and writes to them are discarded.
- R10: Opcodes 0, 6 and 7 change no register and no memory, and advance the PC by 4.
- R11: imem_addr and dmem_addr always have bits [1:0] equal to 00; a misaligned effective address is rounded down to its word.
- R12: An add whose unsigned result wraps can be detected by a following branch-unsigned-less of the sum against an operand, which is then taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Fetch byte address (the PC) |
| imem_rdata | input | 32 | Instruction word at imem_addr, same cycle |
| dmem_addr | output | 32 | Word-aligned data address |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, written at the next rising edge |
| dmem_rdata | input | 32 | Data word at dmem_addr, same cycle |

## Verification
The bench runs a short program and compares each store in order against a queue of expected stores. Immediate tests use the extremes 0x7FFF, 0x8000 and all-ones, which separate sign extension from zero extension. Branch tests use an operand pair that is ordered one way as signed numbers and the other way as unsigned numbers, an equal pair, and a backward loop, which separate unsigned from signed comparison, strict from non-strict comparison, and forward from backward offsets. Further tests write to register zero, to an unimplemented index, and through reserved opcodes, store through a misaligned offset, and run the overflow idiom with and without a wrap. Each of these shows whether the expected value or the leaked value reaches memory.

// File: rtl/cpu_pkg.sv
package cpu_pkg;
  localparam int INSN_W = 32;
  localparam int IMM_W  = 16;
  localparam int RIDX_W = 4;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_ADDI = 3'd1,
    OP_ADD  = 3'd2,
    OP_LW   = 3'd3,
    OP_SW   = 3'd4,
    OP_BLTU = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } opcode_e;

  typedef struct packed {
    logic              reg_wr;
    logic              imm_sel;
    logic              mem_rd;
    logic              mem_wr;
    logic              branch;
    logic [RIDX_W-1:0] rd;
    logic [RIDX_W-1:0] ra_idx;
    logic [RIDX_W-1:0] rb_idx;
    logic [IMM_W-1:0]  imm;
  } ctrl_t;
endpackage

// File: rtl/cpu_decode.sv
module cpu_decode
  import cpu_pkg::*;
(
  input  logic [INSN_W-1:0] instr,
  output ctrl_t             ctrl
);
  opcode_e op;
  logic    unused_spare;

  assign op           = opcode_e'(instr[31:29]);
  assign unused_spare = instr[16];

  always_comb begin
    ctrl        = '0;
    ctrl.rd     = instr[28:25];
    ctrl.ra_idx = instr[24:21];
    ctrl.rb_idx = instr[20:17];
    ctrl.imm    = instr[15:0];
    case (op)
      OP_ADDI: begin
        ctrl.reg_wr  = 1'b1;
        ctrl.imm_sel = 1'b1;
      end
      OP_ADD: ctrl.reg_wr = 1'b1;
      OP_LW: begin
        ctrl.reg_wr  = 1'b1;
        ctrl.imm_sel = 1'b1;
        ctrl.mem_rd  = 1'b1;
      end
      OP_SW: begin
        ctrl.imm_sel = 1'b1;
        ctrl.mem_wr  = 1'b1;
        ctrl.rb_idx  = instr[28:25];
      end
      OP_BLTU: ctrl.branch = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile #(
  parameter int XLEN  = 32,
  parameter int NREGS = 11,
  parameter int AW    = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [AW-1:0]   wa,
  input  logic [XLEN-1:0] wd,
  input  logic [AW-1:0]   ra_a,
  input  logic [AW-1:0]   ra_b,
  output logic [XLEN-1:0] rd_a,
  output logic [XLEN-1:0] rd_b
);
  logic [XLEN-1:0] regs [1:NREGS-1];

  for (genvar g = 1; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) regs[g] <= '0;
      else if (we && wa == AW'(g)) regs[g] <= wd;
    end
  end

  always_comb begin
    rd_a = '0;
    rd_b = '0;
    for (int i = 1; i < NREGS; i++) begin
      if (ra_a == AW'(i)) rd_a = regs[i];
      if (ra_b == AW'(i)) rd_b = regs[i];
    end
  end
endmodule

// File: rtl/cpu_exec.sv
module cpu_exec #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16
) (
  input  logic [XLEN-1:0]  pc,
  input  logic [XLEN-1:0]  opa,
  input  logic [XLEN-1:0]  opb_reg,
  input  logic [IMM_W-1:0] imm,
  input  logic             imm_sel,
  input  logic             branch,
  output logic [XLEN-1:0]  sum,
  output logic [XLEN-1:0]  pc_next
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [XLEN-1:0] imm_x;
  logic [XLEN-1:0] opb;
  logic [XLEN-1:0] pc_seq;
  logic            below;

  assign imm_x   = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
  assign opb     = imm_sel ? imm_x : opb_reg;
  assign sum     = opa + opb;
  assign below   = opa < opb_reg;
  assign pc_seq  = pc + STEP;
  assign pc_next = (branch && below) ? pc_seq + (imm_x << 2) : pc_seq;
endmodule

// File: rtl/cpu_core.sv
module cpu_core
  import cpu_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NREGS = 11
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] imem_addr,
  input  logic [31:0]     imem_rdata,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  output logic            dmem_we,
  input  logic [XLEN-1:0] dmem_rdata
);
  ctrl_t           ctrl;
  logic [XLEN-1:0] pc, pc_next;
  logic [XLEN-1:0] va, vb, sum, wb;
  logic [1:0]      unused_lsb;

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_next;
  end

  cpu_decode u_dec (
    .instr (imem_rdata),
    .ctrl  (ctrl)
  );

  cpu_regfile #(.XLEN(XLEN), .NREGS(NREGS), .AW(RIDX_W)) u_rf (
    .clk  (clk),
    .rst  (rst),
    .we   (ctrl.reg_wr),
    .wa   (ctrl.rd),
    .wd   (wb),
    .ra_a (ctrl.ra_idx),
    .ra_b (ctrl.rb_idx),
    .rd_a (va),
    .rd_b (vb)
  );

  cpu_exec #(.XLEN(XLEN), .IMM_W(IMM_W)) u_ex (
    .pc      (pc),
    .opa     (va),
    .opb_reg (vb),
    .imm     (ctrl.imm),
    .imm_sel (ctrl.imm_sel),
    .branch  (ctrl.branch),
    .sum     (sum),
    .pc_next (pc_next)
  );

  assign wb         = ctrl.mem_rd ? dmem_rdata : sum;
  assign unused_lsb = sum[1:0];
  assign imem_addr  = pc;
  assign dmem_addr  = {sum[XLEN-1:2], 2'b00};
  assign dmem_wdata = vb;
  assign dmem_we    = ctrl.mem_wr;
endmodule

// File: rtl/cpu_core_chk.sv
module cpu_core_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic [XLEN-1:0] imem_addr,
  input logic [31:0]     imem_rdata,
  input logic [XLEN-1:0] dmem_addr,
  input logic            dmem_we
);
  logic [2:0]      op;
  logic [XLEN-1:0] br_tgt;
  logic            unused_chk;

  assign op         = imem_rdata[31:29];
  assign br_tgt     = imem_addr + XLEN'(4) + ({{(XLEN-16){imem_rdata[15]}}, imem_rdata[15:0]} << 2);
  assign unused_chk = ^{imem_rdata[28:16], dmem_addr[XLEN-1:2]};

  // R2
  reset_pc_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> imem_addr == '0);

  // R11
  pc_align_chk: assert property (@(posedge clk) disable iff (rst)
    imem_addr[1:0] == 2'b00);

  // R11
  dmem_align_chk: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> dmem_addr[1:0] == 2'b00);

  // R6
  store_only_chk: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> op == 3'd4);

  // R10
  seq_pc_chk: assert property (@(posedge clk) disable iff (rst)
    op != 3'd5 |=> imem_addr == $past(imem_addr) + XLEN'(4));

  // R7
  branch_pc_chk: assert property (@(posedge clk) disable iff (rst)
    op == 3'd5 |=> (imem_addr == $past(imem_addr) + XLEN'(4)) || (imem_addr == $past(br_tgt)));
endmodule

bind cpu_core cpu_core_chk #(.XLEN(XLEN)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .imem_addr  (imem_addr),
  .imem_rdata (imem_rdata),
  .dmem_addr  (dmem_addr),
  .dmem_we    (dmem_we)
);

// File: tb/cpu_core_tb.sv
`timescale 1ns/1ps
module cpu_core_tb;
  localparam int ZR = 0, SP = 3, T0 = 4, T1 = 5, T2 = 6, T3 = 7, T4 = 8, T5 = 9, T6 = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;

  logic [31:0] imem [128];
  logic [31:0] dmem [256];

  typedef struct {
    logic [31:0] a;
    logic [31:0] d;
    string       tag;
  } exp_t;
  exp_t q[$];

  int checks = 0, fails = 0, pc_idx = 0, slot = 8;
  logic [31:0] halt_pc;

  always #4 clk = ~clk;

  cpu_core u_dut (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we), .dmem_rdata(dmem_rdata)
  );

  assign imem_rdata = imem[imem_addr[8:2]];
  assign dmem_rdata = dmem[dmem_addr[9:2]];

  always @(posedge clk) begin
    if (rst) begin
      dmem[128] <= 32'h1234_5678;
      dmem[129] <= 32'hCAFE_F00D;
    end else if (dmem_we) dmem[dmem_addr[9:2]] <= dmem_wdata;
  end

  function automatic logic [31:0] enc(input int op, input int rd, input int rs1, input int rs2, input int imm);
    enc = {op[2:0], rd[3:0], rs1[3:0], rs2[3:0], 1'b0, imm[15:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic emit(input logic [31:0] w);
    imem[pc_idx] = w;
    pc_idx++;
  endtask

  task automatic push_exp(input logic [31:0] a, input logic [31:0] d, input string tag);
    exp_t e;
    e.a = a; e.d = d; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic st(input int r, input logic [31:0] val, input string tag);
    emit(enc(4, r, SP, 0, slot * 4));
    push_exp(32'h100 + 32'(slot * 4), val, tag);
    slot++;
  endtask

  // monitor: scoreboard side
  always @(negedge clk) begin
    if (!rst && dmem_we) begin
      if (q.size() == 0) chk(1'b0, "R6 unexpected store", dmem_addr, 32'h0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(dmem_addr == e.a, {e.tag, " addr"}, dmem_addr, e.a);
        chk(dmem_wdata == e.d, {e.tag, " data"}, dmem_wdata, e.d);
      end
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) imem[i] = 32'h0;
    // driver: program and expected stores
    emit(enc(4, T0, ZR, 0, 0));            push_exp(32'h0, 32'h0, "R2 reset regs");
    emit(enc(1, SP, ZR, 0, 32'h100));
    emit(enc(1, T1, ZR, 0, -1));           st(T1, 32'hFFFF_FFFF, "R3 sext -1");
    emit(enc(1, T0, ZR, 0, 32'h7FFF));     st(T0, 32'h0000_7FFF, "R3 max imm");
    emit(enc(1, T0, ZR, 0, -32768));       st(T0, 32'hFFFF_8000, "R3 min imm");
    emit(enc(1, T2, ZR, 0, 2));
    emit(enc(2, T3, T1, T2, 0));           st(T3, 32'h1, "R4 wrap");
    emit(enc(2, T0, T2, T2, 0));           st(T0, 32'h4, "R4 add");
    emit(enc(1, ZR, ZR, 0, 5));
    emit(enc(2, ZR, T2, T2, 0));           st(ZR, 32'h0, "R8 zero reg");
    emit(enc(1, T4, ZR, 0, 32'h204));
    emit(enc(3, T5, T4, 0, -4));           st(T5, 32'h1234_5678, "R5 load neg disp");
    emit(enc(3, T5, T4, 0, 0));            st(T5, 32'hCAFE_F00D, "R5 load");
    emit(enc(4, T2, SP, 0, -4));           push_exp(32'hFC, 32'h2, "R6 store neg disp");
    // R7 taken: 2 <u 0xFFFFFFFF
    emit(enc(1, T6, ZR, 0, 0));
    emit(enc(5, 0, T2, T1, 1));
    emit(enc(1, T6, T6, 0, 32'h11));
    emit(enc(1, T6, T6, 0, 32'h22));       st(T6, 32'h22, "R7 taken unsigned");
    emit(enc(1, T6, ZR, 0, 0));
    emit(enc(5, 0, T1, T2, 1));
    emit(enc(1, T6, T6, 0, 32'h11));
    emit(enc(1, T6, T6, 0, 32'h22));       st(T6, 32'h33, "R7 not taken");
    emit(enc(1, T6, ZR, 0, 0));
    emit(enc(5, 0, T2, T2, 1));
    emit(enc(1, T6, T6, 0, 32'h11));
    emit(enc(1, T6, T6, 0, 32'h22));       st(T6, 32'h33, "R7 equal");
    emit(enc(1, T0, ZR, 0, 0));
    emit(enc(1, T5, ZR, 0, 3));
    emit(enc(1, T0, T0, 0, 1));
    emit(enc(5, 0, T0, T5, -2));           st(T0, 32'h3, "R7 backward loop");
    emit(enc(1, T0, ZR, 0, 32'h44));
    emit(enc(6, T0, ZR, 0, 7));
    emit(enc(0, T0, T0, 0, 1));
    emit(enc(7, T0, T0, T0, 9));           st(T0, 32'h44, "R10 reserved opcodes");
    emit(enc(1, 12, ZR, 0, 9));
    emit(enc(2, T0, 12, T2, 0));           st(T0, 32'h2, "R9 unimplemented reg");
    emit(enc(1, T0, ZR, 0, 6) | 32'h0001_0000);
    st(T0, 32'h6, "R1 spare bit ignored");
    emit(enc(4, T2, SP, 0, 2));            push_exp(32'h100, 32'h2, "R11 misaligned store");
    // R12 overflow idiom
    emit(enc(2, T3, T1, T2, 0));
    emit(enc(1, T6, ZR, 0, 0));
    emit(enc(5, 0, T3, T1, 1));
    emit(enc(1, T6, T6, 0, 32'h11));
    emit(enc(1, T6, T6, 0, 32'h22));       st(T6, 32'h22, "R12 overflow seen");
    emit(enc(1, T1, ZR, 0, 5));
    emit(enc(2, T3, T1, T2, 0));
    emit(enc(1, T6, ZR, 0, 0));
    emit(enc(5, 0, T3, T1, 1));
    emit(enc(1, T6, T6, 0, 32'h11));
    emit(enc(1, T6, T6, 0, 32'h22));       st(T6, 32'h33, "R12 no overflow");
    emit(enc(1, T6, ZR, 0, 1));
    halt_pc = 32'(pc_idx * 4);
    emit(enc(5, 0, ZR, T6, -1));

    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    chk(imem_addr == 32'h0, "R2 reset pc", imem_addr, 32'h0);
    chk(dmem_we == 1'b0 || imem_rdata[31:29] == 3'd4, "R6 strobe", {31'h0, dmem_we}, 32'h0);

    begin
      int cyc = 0;
      while (q.size() != 0 && cyc < 3000) begin
        @(negedge clk);
        cyc++;
      end
      if (q.size() != 0) chk(1'b0, "watchdog pending stores", 32'(q.size()), 32'h0);
    end
    repeat (5) @(negedge clk);
    chk(imem_addr == halt_pc, "R7 halt loop", imem_addr, halt_pc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule